// File: doc/BRIEF.md
# Quad SPI Word Shift Engine

This block is the bit-level serial engine that sits under a flash controller. The controller hands it one word at a time: a command byte, an address, dummy cycles or data. The engine then runs the serial clock, the active-low chip select and the four data lanes until that word has been shifted. A word is 8, 16, 24 or 32 bits long. It moves either one bit per serial clock on a single line or four bits per serial clock on all four lanes. It can be sent out or read back.

When a word ends, the hold input decides what happens next. If hold is high, chip select stays low and the engine waits for the next word of the same transaction, so command, address, dummy and data phases can be chained. If hold is low, chip select is raised and the engine keeps the line high for a minimum gap before it accepts another request. For reads, the received bits arrive right-aligned in a 32-bit result, marked by a one-cycle valid pulse. A lane-mode output tells an external pad block when the lanes are being driven in quad mode and when they must be released for a quad read.

The serial clock runs at half the system clock and idles low (SPI mode 0). Each bit slot takes two system cycles: one with the serial clock low, then one with it high. Outgoing lanes change only when the serial clock falls. Incoming lanes are captured when it rises.

Top module: `qspi_word_engine`

## Requirements
- R1: `req_len` sets the word size: 00 gives 8 bits, 01 gives 16, 10 gives 24 and 11 gives 32. In single-lane mode a word takes 2×bits system cycles, and in quad mode it takes 2×bits/4 system cycles, counted from the cycle after acceptance.
- R2: A write shifts out from bit 31 of `req_word` downward. In single-lane mode the current bit is on `lane_out[0]` and `lane_out[3:1]` are 0. In quad mode each slot drives four bits, with `lane_out[3]` carrying the most significant of the four, starting with `req_word[31:28]`.
- R3: `sck` is low whenever chip select is high. During a word, each slot spends one cycle with `sck` low and then one with it high. `lane_out` changes only in the cycle in which `sck` has just fallen, or in the first cycle of a word.
- R4: During a read word, `lane_out` is all zero. A single-lane read captures `lane_in[1]` once per slot. A quad read captures `lane_in[3:0]` with lane 3 as the most significant bit. Capture happens at the edge where `sck` rises.
- R5: One cycle after the last slot of a read word, `rd_valid` is high for exactly one cycle. `rd_word` then holds the received bits right-aligned and zero-extended, with the first bit received as the most significant. Write words produce no pulse and leave `rd_word` unchanged.
- R6: `busy` is high from the cycle after a request is accepted until the word ends and any chip-select gap is over. It is low when the engine is idle and when it is waiting in a held transaction.
- R7: If `req_hold` is high in the last cycle of a word, chip select stays low and `busy` falls. A request made in that held state starts the next word with chip select still low.
- R8: If `req_hold` is low in the last cycle of a word, chip select rises in the next cycle and stays high for two cycles with `busy` high. After that the engine is idle.
- R9: A request is accepted only when the engine is idle or in a held transaction. A request raised while a word is shifting or during the chip-select gap has no effect on any output.
- R10: `lane_mode` is 00 outside a word and during any single-lane word, 10 during a quad write and 11 during a quad read.
- R11: While `rst_n` is low at a clock edge, the engine returns to idle: `cs_n`=1, `sck`=0, `busy`=0, `rd_valid`=0, `rd_word`=0, `lane_mode`=00, `lane_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request to shift one word |
| req_word | input | 32 | Outgoing word, sent from bit 31 down |
| req_len | input | 2 | Length code (8/16/24/32 bits) |
| req_quad | input | 1 | 0: one lane, 1: four lanes |
| req_read | input | 1 | 0: write word, 1: read word |
| req_hold | input | 1 | Keep chip select low after the word (sampled in its last cycle) |
| lane_in | input | 4 | Incoming lane values from the device |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| lane_mode | output | 2 | 00 single or idle, 10 quad write, 11 quad read |
| lane_out | output | 4 | Outgoing lane values |
| busy | output | 1 | Word shifting or chip-select gap in progress |
| rd_valid | output | 1 | One-cycle pulse when a read word completes |
| rd_word | output | 32 | Received bits, right-aligned |

## Verification
Some properties are checked on every cycle. The serial clock never runs with chip select high, and every rise of `sck` is followed by a fall. Chip select, once raised, stays high for the gap, and `rd_valid` never lasts two cycles. Quad reads never drive the lanes, the lanes change only on a falling `sck`, and a request that arrives while shifting or in the gap leaves the engine's state unchanged. Only the bench scenarios can show the rest, because it depends on matching a word's content and length against the waveform. That covers MSB-first lane order for each length and lane mode, the right-aligned result of a read, chip select held low across chained words and idle waits, and stray requests leaving the outputs untouched.

// File: rtl/qwe_pkg.sv
`timescale 1ns/1ps
// Shared types for the quad SPI word shift engine.
// Assumes: the four engine states are the only ones the sequencer needs.
package qwe_pkg;
    typedef enum logic [1:0] {
        QWE_IDLE  = 2'd0,   // chip select high, ready for a request
        QWE_SHIFT = 2'd1,   // a word is being shifted
        QWE_HELD  = 2'd2,   // chip select low, waiting for the next word
        QWE_GAP   = 2'd3    // chip select high, minimum gap running
    } qwe_state_e;

    localparam int unsigned QWE_LEN_W = 2;
endpackage

// File: rtl/qwe_seq.sv
`timescale 1ns/1ps
// Phase sequencer: accepts requests, counts bit slots, and generates
// the serial clock and chip select together with the load, advance,
// sample and done strobes for the shifters.
// Assumes: WORD_W is a multiple of 4*QUAD_W, and QUAD_W is a power of two.
module qwe_seq
    import qwe_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned QUAD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [QWE_LEN_W-1:0] req_len,
    input  logic                 req_quad,
    input  logic                 req_read,
    input  logic                 req_hold,
    output qwe_state_e           state_o,
    output logic                 load_o,
    output logic                 adv_o,
    output logic                 smp_o,
    output logic                 done_o,
    output logic                 active_o,
    output logic                 busy_o,
    output logic                 quad_o,
    output logic                 read_o,
    output logic                 sck_o,
    output logic                 cs_n_o
);
    localparam int unsigned SLOT_W = $clog2(WORD_W + 1);
    localparam int unsigned BYTE_W = WORD_W / 4;
    localparam int unsigned QSH    = $clog2(QUAD_W);

    qwe_state_e        state_q;
    logic              ph_q;
    logic              gap_q;
    logic              sck_q;
    logic              cs_n_q;
    logic              quad_q;
    logic              read_q;
    logic [SLOT_W-1:0] slots_q;
    logic [SLOT_W-1:0] bits_req;
    logic [SLOT_W-1:0] slots_req;
    logic              last_slot;

    // Translate the length code and lane mode into a slot count.
    always_comb begin
        bits_req  = SLOT_W'(BYTE_W) * (SLOT_W'(req_len) + SLOT_W'(1));
        slots_req = req_quad ? (bits_req >> QSH) : bits_req;
    end

    assign last_slot = (slots_q == SLOT_W'(1));
    assign load_o    = req && ((state_q == QWE_IDLE) || (state_q == QWE_HELD));
    assign smp_o     = (state_q == QWE_SHIFT) && !ph_q;
    assign adv_o     = (state_q == QWE_SHIFT) && ph_q && !last_slot;
    assign done_o    = (state_q == QWE_SHIFT) && ph_q && last_slot;
    assign active_o  = (state_q == QWE_SHIFT);
    assign busy_o    = (state_q == QWE_SHIFT) || (state_q == QWE_GAP);
    assign state_o   = state_q;
    assign quad_o    = quad_q;
    assign read_o    = read_q;
    assign sck_o     = sck_q;
    assign cs_n_o    = cs_n_q;

    // State, phase, slot counter, serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QWE_IDLE;
            ph_q    <= 1'b0;
            gap_q   <= 1'b0;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            quad_q  <= 1'b0;
            read_q  <= 1'b0;
            slots_q <= '0;
        end else begin
            case (state_q)
                QWE_IDLE, QWE_HELD: begin
                    if (req) begin
                        state_q <= QWE_SHIFT;
                        ph_q    <= 1'b0;
                        sck_q   <= 1'b0;
                        cs_n_q  <= 1'b0;
                        quad_q  <= req_quad;
                        read_q  <= req_read;
                        slots_q <= slots_req;
                    end
                end
                QWE_SHIFT: begin
                    if (!ph_q) begin
                        ph_q  <= 1'b1;
                        sck_q <= 1'b1;
                    end else begin
                        ph_q  <= 1'b0;
                        sck_q <= 1'b0;
                        if (last_slot) begin
                            state_q <= req_hold ? QWE_HELD : QWE_GAP;
                            cs_n_q  <= !req_hold;
                            gap_q   <= 1'b0;
                        end else begin
                            slots_q <= slots_q - SLOT_W'(1);
                        end
                    end
                end
                default: begin
                    if (gap_q) begin
                        state_q <= QWE_IDLE;
                    end else begin
                        gap_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> !cs_n_q);  // R3
    AST_SCK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |=> $fell(sck_q));  // R3
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |=> cs_n_q);  // R8
    AST_REQ_IGNORED_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (state_q == QWE_SHIFT) && !(ph_q && last_slot)) |=> (state_q == QWE_SHIFT));  // R9
    AST_REQ_IGNORED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (state_q == QWE_GAP) && !gap_q) |=> (state_q == QWE_GAP));  // R9
endmodule

// File: rtl/qwe_tx.sv
`timescale 1ns/1ps
// Transmit shifter: holds the outgoing word and presents its top bits
// on the lanes, one bit or one nibble per slot.
// Assumes: load and advance are never high in the same cycle.
module qwe_tx #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned QUAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              active,
    input  logic              quad,
    input  logic              read,
    input  logic [WORD_W-1:0] word,
    output logic [QUAD_W-1:0] lane_out
);
    logic [WORD_W-1:0] sreg_q;

    // Load on acceptance; shift by one lane group when the clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= word;
        end else if (adv) begin
            sreg_q <= quad ? (sreg_q << QUAD_W) : (sreg_q << 1);
        end
    end

    // Drive the lanes only while a write word is active.
    always_comb begin
        if (!active || read) begin
            lane_out = '0;
        end else if (quad) begin
            lane_out = sreg_q[WORD_W-1 -: QUAD_W];
        end else begin
            lane_out = QUAD_W'(sreg_q[WORD_W-1]);
        end
    end
endmodule

// File: rtl/qwe_rx.sv
`timescale 1ns/1ps
// Receive shifter: clears at word start, captures the lanes on each
// rising serial clock, and publishes the result with a valid pulse.
// Assumes: single-lane data arrives on lane 1.
module qwe_rx #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned QUAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              smp,
    input  logic              done,
    input  logic              quad,
    input  logic              read,
    input  logic [QUAD_W-1:0] lane_in,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] sreg_q;

    // Collect incoming bits at the LSB end so that the result is right-aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= '0;
        end else if (smp) begin
            sreg_q <= quad ? {sreg_q[WORD_W-QUAD_W-1:0], lane_in}
                           : {sreg_q[WORD_W-2:0], lane_in[1]};
        end
    end

    // Publish the result and pulse valid when a read word finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= done && read;
            if (done && read) begin
                rd_word <= sreg_q;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R5
endmodule

// File: rtl/qspi_word_engine.sv
`timescale 1ns/1ps
// Quad SPI word shift engine top: moves one 8..32 bit word per request
// over one or four lanes in SPI mode 0, and holds chip select across
// words on request.
// Assumes: an external pad block uses lane_mode to set the lane directions.
module qspi_word_engine
    import qwe_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned QUAD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [WORD_W-1:0]    req_word,
    input  logic [QWE_LEN_W-1:0] req_len,
    input  logic                 req_quad,
    input  logic                 req_read,
    input  logic                 req_hold,
    input  logic [QUAD_W-1:0]    lane_in,
    output logic                 sck,
    output logic                 cs_n,
    output logic [1:0]           lane_mode,
    output logic [QUAD_W-1:0]    lane_out,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_word
);
    qwe_state_e state;
    logic       load, adv, smp, done, active, quad, read;

    qwe_seq #(.WORD_W(WORD_W), .QUAD_W(QUAD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_len(req_len),
        .req_quad(req_quad), .req_read(req_read), .req_hold(req_hold),
        .state_o(state), .load_o(load), .adv_o(adv), .smp_o(smp),
        .done_o(done), .active_o(active), .busy_o(busy), .quad_o(quad),
        .read_o(read), .sck_o(sck), .cs_n_o(cs_n)
    );

    qwe_tx #(.WORD_W(WORD_W), .QUAD_W(QUAD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .active(active),
        .quad(quad), .read(read), .word(req_word), .lane_out(lane_out)
    );

    qwe_rx #(.WORD_W(WORD_W), .QUAD_W(QUAD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(load), .smp(smp), .done(done),
        .quad(quad), .read(read), .lane_in(lane_in),
        .rd_valid(rd_valid), .rd_word(rd_word)
    );

    // Report lane usage to the pad block.
    assign lane_mode = (active && quad) ? {1'b1, read} : 2'b00;

    AST_QREAD_LANES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == 2'b11) |-> (lane_out == '0));  // R4
    AST_LANES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$fell(sck)) |-> $stable(lane_out));  // R3
    AST_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == QWE_IDLE) |-> (cs_n && !busy && !sck));  // R6
endmodule

// File: tb/tb_qspi_word_engine.sv
`timescale 1ns/1ps
// Cycle-level reference bench: a behavioural model of the expected
// waveform is compared with every output on every clock (at the falling edge).
module tb_qspi_word_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_word = '0;
    logic [1:0]  req_len = '0;
    logic        req_quad = 1'b0;
    logic        req_read = 1'b0;
    logic        req_hold = 1'b0;
    logic [3:0]  lane_in = '0;
    logic        sck, cs_n, busy, rd_valid;
    logic [1:0]  lane_mode;
    logic [3:0]  lane_out;
    logic [31:0] rd_word;

    int          vectors = 0;
    int          miscompares = 0;
    logic [31:0] exp_rword = '0;
    bit          held_now = 1'b0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    qspi_word_engine dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_word(req_word),
        .req_len(req_len), .req_quad(req_quad), .req_read(req_read),
        .req_hold(req_hold), .lane_in(lane_in), .sck(sck), .cs_n(cs_n),
        .lane_mode(lane_mode), .lane_out(lane_out), .busy(busy),
        .rd_valid(rd_valid), .rd_word(rd_word)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic expect_cycle(input string tag, input bit e_cs, input bit e_sck,
                                input bit e_busy, input logic [3:0] e_lane,
                                input logic [1:0] e_mode, input bit e_valid);
        chk(tag, "cs_n", {31'b0, cs_n}, {31'b0, e_cs});
        chk(tag, "sck", {31'b0, sck}, {31'b0, e_sck});
        chk(tag, "busy", {31'b0, busy}, {31'b0, e_busy});
        chk(tag, "lane_out", {28'b0, lane_out}, {28'b0, e_lane});
        chk(tag, "lane_mode", {30'b0, lane_mode}, {30'b0, e_mode});
        chk(tag, "rd_valid", {31'b0, rd_valid}, {31'b0, e_valid});
        chk(tag, "rd_word", rd_word, exp_rword);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_cycle(held_now ? "R7 held" : "R6 idle", !held_now, 1'b0,
                         1'b0, 4'h0, 2'b00, 1'b0);
        end
    endtask

    // One word, from request to the end of the chip-select gap.
    task automatic run_word(input logic [31:0] word, input logic [1:0] len,
                            input bit quad, input bit rd, input bit hold,
                            input logic [31:0] pat, input bit stray);
        int          bits;
        int          slots;
        int          k;
        logic [63:0] mask;
        logic [3:0]  e_lane;
        logic [1:0]  e_mode;
        bits   = 8 * (int'(len) + 1);
        slots  = quad ? bits / 4 : bits;
        mask   = (64'd1 << bits) - 64'd1;
        e_mode = quad ? {1'b1, rd} : 2'b00;
        req = 1'b1; req_word = word; req_len = len;
        req_quad = quad; req_read = rd; req_hold = hold;
        for (int c = 0; c < 2 * slots; c++) begin
            @(negedge clk);
            k = c / 2;
            if (c == 0) begin
                req = 1'b0; req_word = ~word; req_len = ~len;
                req_quad = ~quad; req_read = ~rd;
            end
            if (stray && c == 2) req = 1'b1;
            if (stray && c == 3) req = 1'b0;
            if (rd) e_lane = 4'h0;
            else if (quad) e_lane = 4'((word >> (28 - 4 * k)) & 32'hF);
            else e_lane = {3'b000, word[31 - k]};
            expect_cycle(rd ? (stray ? "R1 R3 R4 R10 R9" : "R1 R3 R4 R10")
                            : (stray ? "R1 R2 R3 R10 R9" : "R1 R2 R3 R10"),
                         1'b0, c[0], 1'b1, e_lane, e_mode, 1'b0);
            if (c % 2 == 0) begin
                if (quad) lane_in = 4'((pat >> (bits - 4 - 4 * k)) & 32'hF);
                else lane_in = 4'b1101 | {2'b00, pat[bits - 1 - k], 1'b0};
            end
        end
        @(negedge clk);
        if (rd) exp_rword = pat & mask[31:0];
        expect_cycle(hold ? "R5 R7" : "R5 R8", !hold, 1'b0, !hold, 4'h0, 2'b00, rd);
        if (stray && !hold) begin
            req = 1'b1; req_word = 32'hFFFF_FFFF; req_len = 2'b11;
        end
        if (!hold) begin
            @(negedge clk);
            req = 1'b0;
            expect_cycle("R8 R9 gap", 1'b1, 1'b0, 1'b1, 4'h0, 2'b00, 1'b0);
        end
        held_now = hold;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_cycle("R11 reset", 1'b1, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0);
        rst_n = 1'b1;
        idle(3);

        // Single-lane writes, all lengths (R1 R2).
        for (int l = 0; l < 4; l++) begin
            run_word(32'hA5C3_9617 ^ (l * 32'h1111_0000), 2'(l), 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
            idle(2);
        end
        // Quad writes, all lengths.
        for (int l = 0; l < 4; l++) begin
            run_word(32'h3C5A_F01E + l * 32'h0102_0304, 2'(l), 1'b1, 1'b0, 1'b0, 32'h0, 1'b0);
            idle(2);
        end
        // Single-lane reads, all lengths (R4 R5).
        for (int l = 0; l < 4; l++) begin
            run_word(32'h0, 2'(l), 1'b0, 1'b1, 1'b0, 32'hD3B6_5A97 ^ (l * 32'h0F0F), 1'b0);
            idle(2);
        end
        // Quad reads, all lengths.
        for (int l = 0; l < 4; l++) begin
            run_word(32'hFFFF_FFFF, 2'(l), 1'b1, 1'b1, 1'b0, 32'h8E27_C1F4 + l * 32'h1357, 1'b0);
            idle(2);
        end
        // Chained transaction with chip select held (R7).
        run_word(32'hEB00_0000, 2'b00, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
        idle(4);
        run_word(32'h1234_56A0, 2'b11, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0);
        run_word(32'h0, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_00C7, 1'b0);
        idle(2);
        run_word(32'h0, 2'b11, 1'b1, 1'b1, 1'b0, 32'h7F01_88E4, 1'b0);
        idle(3);
        // Stray requests during shifting and during the gap (R9).
        run_word(32'h6D29_B4F0, 2'b01, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
        idle(3);
        run_word(32'h0, 2'b10, 1'b1, 1'b1, 1'b0, 32'h00AB_CDEF, 1'b1);
        idle(3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule